// File: doc/BRIEF.md
# LCD Refresh DMA Engine

This block keeps a monochrome LCD panel fed with pixels without help from the CPU. After reset it runs without pause. It walks through a picture held in RAM and issues one byte read at a time on a memory port that has priority over the CPU. That port stays usable even when the CPU's own access to RAM is switched off. Each byte that comes back is passed on to the panel side with a valid strobe. Two flags mark the first byte of each row and the first byte of each logical frame.

Software sets the picture geometry through a small set of configuration inputs: a row-count code, a column-count code, a pacing bit and the start address of the picture. The engine takes a fresh copy of these settings only when a logical frame begins, so no frame ever mixes two settings. Logical frames follow one another with no gap. When a frame has fewer than 64 rows, the picture therefore repeats down the 64 physical rows of the panel. A one-cycle interrupt marks the end of every logical frame. Shorter frames give proportionally more interrupts.

The memory port contract is simple: data for a read issued in one cycle is on `mem_rdata` in the next cycle.

Top module: `lcd_refresh_dma`

## Requirements
- R1: The row code `cfg_rows` sets the rows per logical frame: 00 gives 16, 01 gives 32, 10 gives 48 and 11 gives 64.
- R2: The column code `cfg_cols` sets the pixels per row: 00 gives 80, 01 gives 96, 10 gives 128 and 11 gives 160. That is 10, 12, 16 or 20 bytes per row. `pix_row_start` is high on the first byte of every row and on no other byte.
- R3: With `cfg_fast` at 1, a read is issued every 2 cycles. With `cfg_fast` at 0, a read is issued every 6 cycles (default parameters). `mem_rd` is never high in two consecutive cycles.
- R4: Read addresses start at the frame base, rise by one per byte across row boundaries, wrap modulo 2^ADDR_W, and return to the base at the start of every logical frame.
- R5: `pix_valid` is high exactly in the cycle after each `mem_rd` and carries that read's `mem_rdata`. `pix_frame_start` is high, together with `pix_row_start`, on the first byte of each logical frame.
- R6: `frame_irq` is a one-cycle pulse that coincides with `pix_valid` of the last byte of each logical frame. Frames run back to back, so row codes 00, 01 and 10 give 4, 2 and 4/3 times the interrupt rate of code 11 at equal pacing.
- R7: Configuration inputs are taken only at the first read of a logical frame. A change in the middle of a frame leaves that frame's addresses, lengths and pacing untouched and takes effect from the next frame.
- R8: While `rst` is high, `mem_rd`, `pix_valid`, both flags and `frame_irq` are low. The first `mem_rd`, at `cfg_base`, is issued in the first cycle with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rows | input | 2 | Row-count code |
| cfg_cols | input | 2 | Column-count code |
| cfg_fast | input | 1 | Pacing select, 1 = fast |
| cfg_base | input | ADDR_W | Picture start address |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| pix_valid | output | 1 | Pixel byte strobe |
| pix_data | output | DATA_W | Pixel byte |
| pix_row_start | output | 1 | First byte of a row |
| pix_frame_start | output | 1 | First byte of a logical frame |
| frame_irq | output | 1 | End-of-logical-frame pulse |

## Verification
A wrong column or row counter moves the row-start flag or the interrupt off the expected byte. That shows at the first row or frame boundary, within 20 or 1280 reads. A stray address offset or a missed return to the base gives a wrong address on the very next read, or on the first read of the following frame. Pacing errors show as a wrong spacing between two consecutive reads. A configuration copy taken at the wrong moment shows as a row length, base or spacing that changes in the middle of a frame. The scoreboard checks every read and every pixel byte, so each of these is caught on the first byte it affects.

// File: rtl/lcd_dma_pkg.sv
`timescale 1ns/1ps
package lcd_dma_pkg;

    // Configuration captured at the start of each logical frame
    typedef struct packed {
        logic [1:0] rows_sel;
        logic [1:0] cols_sel;
        logic       fast;
    } scan_cfg_t;

    localparam int ROW_CW = 6;   // up to 64 rows
    localparam int COL_CW = 5;   // up to 20 bytes per row

    // Index of the last row of a logical frame: 15, 31, 47, 63
    function automatic logic [ROW_CW-1:0] last_row_idx(input logic [1:0] sel);
        return ROW_CW'(16 * (int'(sel) + 1) - 1);
    endfunction

    // Index of the last byte in a row: 80/96/128/160 pixels, 8 per byte
    function automatic logic [COL_CW-1:0] last_col_idx(input logic [1:0] sel);
        logic [COL_CW-1:0] r;
        case (sel)
            2'b00:   r = COL_CW'(9);
            2'b01:   r = COL_CW'(11);
            2'b10:   r = COL_CW'(15);
            default: r = COL_CW'(19);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcd_dma_pacer.sv
`timescale 1ns/1ps
module lcd_dma_pacer #(
    parameter int SLOW_GAP = 6,
    parameter int FAST_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic fire
);
    localparam int MAX_GAP = (SLOW_GAP > FAST_GAP) ? SLOW_GAP : FAST_GAP;
    localparam int CW      = $clog2(MAX_GAP + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_st_t;

    pace_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = !rst && (st_q.cnt == '0);
        if (fire) begin
            st_d.cnt = fast ? CW'(FAST_GAP - 1) : CW'(SLOW_GAP - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/lcd_dma_walker.sv
`timescale 1ns/1ps
module lcd_dma_walker
    import lcd_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  scan_cfg_t         cfg_in,
    input  logic [ADDR_W-1:0] base_in,
    output logic              eff_fast,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              row_first,
    output logic              frame_first,
    output logic              frame_last
);
    typedef struct packed {
        logic [COL_CW-1:0] col;
        logic [ROW_CW-1:0] row;
        logic [ADDR_W-1:0] off;
        logic              fresh;   // next read opens a logical frame
        scan_cfg_t         cfg;
        logic [ADDR_W-1:0] base;
    } walk_st_t;

    walk_st_t          st_d, st_q;
    scan_cfg_t         eff_cfg;
    logic [ADDR_W-1:0] eff_base;
    logic              last_col, last_row;

    always_comb begin
        eff_cfg  = st_q.fresh ? cfg_in  : st_q.cfg;
        eff_base = st_q.fresh ? base_in : st_q.base;
        last_col = (st_q.col == last_col_idx(eff_cfg.cols_sel));
        last_row = (st_q.row == last_row_idx(eff_cfg.rows_sel));

        eff_fast    = eff_cfg.fast;
        rd_addr     = eff_base + st_q.off;
        row_first   = (st_q.col == '0);
        frame_first = st_q.fresh;
        frame_last  = last_col && last_row;

        st_d = st_q;
        if (fire) begin
            st_d.fresh = 1'b0;
            st_d.cfg   = eff_cfg;
            st_d.base  = eff_base;
            if (last_col && last_row) begin
                st_d.col   = '0;
                st_d.row   = '0;
                st_d.off   = '0;
                st_d.fresh = 1'b1;
            end else if (last_col) begin
                st_d.col = '0;
                st_d.row = st_q.row + 1'b1;
                st_d.off = st_q.off + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
                st_d.off = st_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lcd_refresh_dma.sv
`timescale 1ns/1ps
module lcd_refresh_dma
    import lcd_dma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int SLOW_GAP = 6,
    parameter int FAST_GAP = 2   // must be at least 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_rows,
    input  logic [1:0]        cfg_cols,
    input  logic              cfg_fast,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_row_start,
    output logic              pix_frame_start,
    output logic              frame_irq
);
    typedef struct packed {
        logic valid;
        logic row_start;
        logic frame_start;
        logic irq;
    } pix_st_t;

    scan_cfg_t         cfg_live;
    logic              fire, eff_fast;
    logic              row_first, frame_first, frame_last;
    logic [ADDR_W-1:0] rd_addr;
    pix_st_t           out_d, out_q;

    assign cfg_live = '{rows_sel: cfg_rows, cols_sel: cfg_cols, fast: cfg_fast};

    lcd_dma_pacer #(
        .SLOW_GAP (SLOW_GAP),
        .FAST_GAP (FAST_GAP)
    ) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .fast (eff_fast),
        .fire (fire)
    );

    lcd_dma_walker #(
        .ADDR_W (ADDR_W)
    ) u_walker (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .cfg_in      (cfg_live),
        .base_in     (cfg_base),
        .eff_fast    (eff_fast),
        .rd_addr     (rd_addr),
        .row_first   (row_first),
        .frame_first (frame_first),
        .frame_last  (frame_last)
    );

    assign mem_rd   = fire;
    assign mem_addr = rd_addr;

    always_comb begin
        out_d.valid       = fire;
        out_d.row_start   = fire && row_first;
        out_d.frame_start = fire && frame_first;
        out_d.irq         = fire && frame_last;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign pix_valid       = out_q.valid;
    assign pix_data        = mem_rdata;
    assign pix_row_start   = out_q.row_start;
    assign pix_frame_start = out_q.frame_start;
    assign frame_irq       = out_q.irq;

endmodule

// File: rtl/lcd_refresh_dma_chk.sv
`timescale 1ns/1ps
module lcd_refresh_dma_chk (
    input logic clk,
    input logic rst,
    input logic mem_rd,
    input logic pix_valid,
    input logic pix_row_start,
    input logic pix_frame_start,
    input logic frame_irq
);
    // R3
    fetch_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R5
    byte_echo_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> pix_valid);

    // R5
    no_stray_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |=> !pix_valid);

    // R5
    frame_row_flag_chk: assert property (@(posedge clk) disable iff (rst)
        pix_frame_start |-> pix_row_start);

    // R2
    row_flag_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pix_row_start |-> pix_valid);

    // R6
    irq_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        frame_irq |-> pix_valid);

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_irq |=> !frame_irq);

endmodule

bind lcd_refresh_dma lcd_refresh_dma_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .mem_rd          (mem_rd),
    .pix_valid       (pix_valid),
    .pix_row_start   (pix_row_start),
    .pix_frame_start (pix_frame_start),
    .frame_irq       (frame_irq)
);

// File: tb/lcd_refresh_dma_tb.sv
`timescale 1ns/1ps
module lcd_refresh_dma_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_rows, cfg_cols;
    logic          cfg_fast;
    logic [AW-1:0] cfg_base;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    logic          pix_valid, pix_row_start, pix_frame_start, frame_irq;
    logic [7:0]    pix_data;

    always #2.5 clk = ~clk;   // 200 MHz

    lcd_refresh_dma u_dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_rows        (cfg_rows),
        .cfg_cols        (cfg_cols),
        .cfg_fast        (cfg_fast),
        .cfg_base        (cfg_base),
        .mem_rd          (mem_rd),
        .mem_addr        (mem_addr),
        .mem_rdata       (mem_rdata),
        .pix_valid       (pix_valid),
        .pix_data        (pix_data),
        .pix_row_start   (pix_row_start),
        .pix_frame_start (pix_frame_start),
        .frame_irq       (frame_irq)
    );

    function automatic logic [7:0] ram_word(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // RAM model: data one cycle after the read strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= ram_word(mem_addr);

    typedef struct {
        logic [AW-1:0] addr;
        bit            rs, fs, irq;
        int            gap;
        string         tag;
    } exp_t;

    exp_t sb[$];
    exp_t pend;
    bit   pend_ok = 0;
    bit   done = 0;
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0, last_fetch = 0;
    int   prev_gap = 0;
    int   last_len = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Driver: expected reads of one logical frame (R1 rows, R2 bytes, R3 pacing, R4 addresses)
    task automatic push_frame(input logic [1:0] rs, input logic [1:0] cs, input bit fast,
                              input logic [AW-1:0] base, input string tag);
        int nrows = 16 * (int'(rs) + 1);
        int nb    = (cs == 2'b00) ? 10 : (cs == 2'b01) ? 12 : (cs == 2'b10) ? 16 : 20;
        logic [AW-1:0] off = '0;
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < nb; c++) begin
                exp_t e;
                e.addr = base + off;
                e.rs   = (c == 0);
                e.fs   = (r == 0) && (c == 0);
                e.irq  = (r == nrows - 1) && (c == nb - 1);
                e.gap  = prev_gap;
                e.tag  = tag;
                sb.push_back(e);
                prev_gap = fast ? 2 : 6;
                off++;
            end
        end
        last_len = nrows * nb;
    endtask

    // Monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            if (pix_valid) begin
                if (!pend_ok) begin
                    check(0, "R5", "byte without a read", 1, 0);
                end else begin
                    check(pix_data == ram_word(pend.addr), "R5", "pix_data", pix_data, ram_word(pend.addr));
                    check(pix_row_start == pend.rs, "R2", "row start flag", pix_row_start, pend.rs);
                    check(pix_frame_start == pend.fs, "R1", "frame start flag", pix_frame_start, pend.fs);
                    check(frame_irq == pend.irq, "R6", "frame interrupt", frame_irq, pend.irq);
                    pend_ok = 0;
                end
            end else begin
                check(frame_irq == 1'b0, "R6", "interrupt without byte", frame_irq, 0);
            end
            if (mem_rd) begin
                if (sb.size() == 0) begin
                    check(0, "R4", "read with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(mem_addr == e.addr, e.tag, "read address", mem_addr, e.addr);
                    if (e.gap != 0) check(cyc - last_fetch == e.gap, "R3", "read spacing", cyc - last_fetch, e.gap);
                    last_fetch = cyc;
                    pend = e;
                    pend_ok = 1;
                end
            end
        end
    end

    task automatic wait_mid_frame();
        int thr = last_len / 2;
        while (sb.size() > thr) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        cfg_rows = 2'b00; cfg_cols = 2'b00; cfg_fast = 1'b1; cfg_base = 16'h0100;
        // R8: quiet outputs in reset
        repeat (5) begin
            @(negedge clk);
            check(!mem_rd && !pix_valid && !frame_irq && !pix_row_start && !pix_frame_start,
                  "R8", "outputs in reset", {mem_rd, pix_valid, frame_irq}, 0);
        end
        // Two identical short frames: back to base (R4), repetition (R6)
        push_frame(2'b00, 2'b00, 1'b1, 16'h0100, "R4");
        push_frame(2'b00, 2'b00, 1'b1, 16'h0100, "R6");
        @(posedge clk);
        #1 rst = 1'b0;
        #0.5;
        check(mem_rd == 1'b1, "R8", "first read after reset", mem_rd, 1);
        check(mem_addr == 16'h0100, "R8", "first read address", mem_addr, 16'h0100);

        // R7: every change below lands mid-frame and must wait for the next frame
        wait_mid_frame();
        cfg_rows = 2'b01; cfg_cols = 2'b01; cfg_fast = 1'b0; cfg_base = 16'hFFF8;
        push_frame(2'b01, 2'b01, 1'b0, 16'hFFF8, "R7");   // address wrap R4

        wait_mid_frame();
        cfg_rows = 2'b10; cfg_cols = 2'b10; cfg_fast = 1'b1; cfg_base = 16'h2000;
        push_frame(2'b10, 2'b10, 1'b1, 16'h2000, "R7");

        wait_mid_frame();
        cfg_rows = 2'b11; cfg_cols = 2'b11; cfg_fast = 1'b0; cfg_base = 16'h4000;
        push_frame(2'b11, 2'b11, 1'b0, 16'h4000, "R1");

        wait_mid_frame();
        cfg_rows = 2'b00; cfg_cols = 2'b00; cfg_fast = 1'b0; cfg_base = 16'h0100;
        push_frame(2'b00, 2'b00, 1'b0, 16'h0100, "R7");

        while (sb.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!pend_ok, "R5", "last byte delivered", pend_ok, 0);
        done = 1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: reads stalled, actual %0d pending expected 0", sb.size());
            summary();
            $finish;
        end
    end

endmodule